// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is an SPI master that a processor drives through three byte-wide registers: a control register, a status register and a data register. A byte written to the data register waits in a one-deep holding stage. It moves into the shift register as soon as the shift register is free. Software can therefore place the next byte while the current one is still on the wire, and the bytes leave back to back with the select line held low for the whole run.

Bytes shift out MSB first, eight per transfer. The serial clock idles low. Each bit is launched on the rising clock edge and captured on the falling edge. The clock half period is set by a divider field. Received bytes land in a receive register. A receive flag reports them, and an overflow flag reports a byte that arrived before the previous one was taken. Both flags clear through a status read followed by a data read.

A debug-halt input blocks data writes unless a control bit allows them. A sleep input leaves the block running and produces a wake request from any enabled interrupt.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset, ss_n is 1, sck is 0, control (addr 0) reads 0x00, status (addr 1) reads 0x01, and all interrupt outputs are 0.
  - Control register fields:
    - bit0: enable.
    - bit1: empty-interrupt enable.
    - bit2: receive-interrupt enable.
    - bit3: error-interrupt enable.
    - bit4: allow writes during halt.
    - bits 7:5: divider.
  - Status register fields:
    - bit0: transmit empty.
    - bit1: receive full.
    - bit2: overflow.
  - Data register: addr 2.
- R2: A write to the data register clears the transmit-empty flag. Once the shift register is free, the byte moves into it, the flag sets again, and ss_n goes low.
- R3: A byte written while another is shifting is held, with the empty flag at 0. It is sent directly after the current byte, ss_n stays low across both, and ss_n rises once when the queue is empty.
- R4: sck idles low. MOSI changes only on a rising sck edge and carries the byte MSB first. MISO is captured on falling sck edges.
- R5: After the eighth falling edge the received byte appears at the data register, and the receive-full flag sets.
- R6: The receive-full flag clears only when a status read made while it is set is followed by a data read. A data read alone leaves it set.
- R7: A byte that completes while receive-full is set sets the overflow flag and leaves the earlier byte in the data register. A status read with overflow set, followed by a data read, clears overflow.
- R8: While dbg_halt is 1 and control bit4 is 0, a data write is ignored: the empty flag stays 1 and no transfer starts. With bit4 set, the write is accepted.
- R9: Each interrupt output is its status flag ANDed with its enable bit and with the enable bit. wake is sleep ANDed with any interrupt output.
- R10: With the enable bit at 0, shifting stops, sck is 0, ss_n is 1, and status reads 0x01.
- R11: sck stays high for divider+1 clock cycles per bit.
- R12: A clearing data read that lands in the same cycle as a byte completing stores the new byte. The receive-full flag stays set and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr | input | 1 | Register write strobe |
| rd | input | 1 | Register read strobe (side effects on flags) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| dbg_halt | input | 1 | Debug halt; blocks data writes unless allowed |
| sleep | input | 1 | Low-power wait indication |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |
| irq_tx | output | 1 | Transmit-empty interrupt request |
| irq_rx | output | 1 | Receive-full interrupt request |
| irq_err | output | 1 | Overflow interrupt request |
| wake | output | 1 | Wake request during sleep |

## Verification
The clearing data read and the completion of an incoming byte can fall in the same clock edge, and the outcome decides whether a byte is lost. The bench arms the clear with a status read while a byte is still waiting, then starts a second transfer. It counts rising sck edges and places the data read on exactly the edge where the eighth falling edge lands. The result is correct when status afterwards shows receive-full set and overflow clear, and the data register holds the second byte.

// File: rtl/spi_dbuf_master.sv
`timescale 1ns/1ps
module spi_dbuf_master #(
  parameter int DW   = 8,
  parameter int DIVW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          dbg_halt,
  input  logic          sleep,
  output logic          sck,
  output logic          mosi,
  input  logic          miso,
  output logic          ss_n,
  output logic          irq_tx,
  output logic          irq_rx,
  output logic          irq_err,
  output logic          wake
);
  localparam int CW = 5 + DIVW;
  localparam int BW = $clog2(DW);
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  logic [CW-1:0]   ctrl;
  logic [DW-1:0]   txd, sh, rxd;
  logic [DIVW-1:0] cnt;
  logic [BW-1:0]   bitc;
  logic            busy, txe, rxf, ovf, rx_arm, ov_arm;

  wire             en         = ctrl[0];
  wire             halt_wr_en = ctrl[4];
  wire [DIVW-1:0]  div        = ctrl[CW-1:5];

  wire st_rd  = rd && addr == A_STAT;
  wire dat_rd = rd && addr == A_DATA;
  wire dat_wr = wr && addr == A_DATA && en && !(dbg_halt && !halt_wr_en);
  wire tick   = busy && cnt == div;
  wire done   = tick && sck && bitc == BW'(DW-1);
  wire load   = !txe && (!busy || done);
  wire rx_clr = dat_rd && rx_arm;
  wire ov_clr = dat_rd && ov_arm;
  wire [DW-1:0] newb = {sh[DW-2:0], miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; txd <= '0; sh <= '0; rxd <= '0; cnt <= '0; bitc <= '0;
      busy <= 1'b0; sck <= 1'b0; mosi <= 1'b0;
      txe <= 1'b1; rxf <= 1'b0; ovf <= 1'b0; rx_arm <= 1'b0; ov_arm <= 1'b0;
    end else begin
      if (wr && addr == A_CTRL) ctrl <= wdata[CW-1:0];
      if (!en) begin
        busy <= 1'b0; sck <= 1'b0; mosi <= 1'b0; cnt <= '0; bitc <= '0;
        txe <= 1'b1; rxf <= 1'b0; ovf <= 1'b0; rx_arm <= 1'b0; ov_arm <= 1'b0;
      end else begin
        if (st_rd && rxf) rx_arm <= 1'b1;
        else if (dat_rd) rx_arm <= 1'b0;
        if (st_rd && ovf) ov_arm <= 1'b1;
        else if (dat_rd) ov_arm <= 1'b0;

        if (dat_wr) txd <= wdata;
        if (dat_wr) txe <= 1'b0;
        else if (load) txe <= 1'b1;

        if (busy) cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) begin
          sck <= ~sck;
          if (!sck) mosi <= sh[DW-1];
          else begin
            sh   <= newb;
            bitc <= bitc + 1'b1;
          end
        end

        if (done) begin
          rxf <= 1'b1;
          if (rxf && !rx_clr) ovf <= 1'b1;
          else rxd <= newb;
        end else begin
          if (rx_clr) rxf <= 1'b0;
          if (ov_clr) ovf <= 1'b0;
        end

        if (load) begin
          sh <= txd; busy <= 1'b1; cnt <= '0; bitc <= '0;
        end else if (done) busy <= 1'b0;
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = DW'(ctrl);
      A_STAT:  rdata = {{(DW-3){1'b0}}, ovf, rxf, txe};
      A_DATA:  rdata = rxd;
      default: rdata = '0;
    endcase
  end

  assign ss_n    = ~busy;
  assign irq_tx  = en && ctrl[1] && txe;
  assign irq_rx  = en && ctrl[2] && rxf;
  assign irq_err = en && ctrl[3] && ovf;
  assign wake    = sleep && (irq_tx || irq_rx || irq_err);
endmodule

module spi_dbuf_master_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          halt_wr_en,
  input logic          dbg_halt,
  input logic          wr,
  input logic          rd,
  input logic [1:0]    addr,
  input logic          sck,
  input logic          ss_n,
  input logic          mosi,
  input logic          txe,
  input logic          rxf,
  input logic          ovf,
  input logic          rx_arm,
  input logic [DW-1:0] rxd
);
  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) ss_n |-> !sck);
  // R4
  mosi_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$rose(sck)) |-> $stable(mosi));
  // R3
  ss_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $rose(ss_n)) |-> $past(txe));
  // R7
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> ($stable(rxd) && $past(rxf)));
  // R6
  rxf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rxf) && $past(en)) |-> $past(rd && addr == 2'd2 && rx_arm));
  // R8
  halt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !halt_wr_en && en && wr && addr == 2'd2 && txe) |=> txe);
  // R10
  off_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en)) |-> (txe && !rxf && !ovf && !sck && ss_n));
endmodule

bind spi_dbuf_master spi_dbuf_master_chk #(.DW(DW)) chk (.*);

// File: tb/tb_spi_dbuf_master.sv
`timescale 1ns/1ps
module tb_spi_dbuf_master;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0, dbg_halt = 1'b0, sleep = 1'b0, miso = 1'b0;
  logic [7:0] wdata = '0;
  wire  [7:0] rdata;
  wire        sck, mosi, ss_n, irq_tx, irq_rx, irq_err, wake;

  spi_dbuf_master dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
    .rdata(rdata), .dbg_halt(dbg_halt), .sleep(sleep), .sck(sck), .mosi(mosi),
    .miso(miso), .ss_n(ss_n), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .irq_err(irq_err), .wake(wake));

  int  tests = 0, fails = 0;
  bit  ended = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_tb();
    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic cpu_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic cpu_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  logic [7:0] sl_q [4];
  logic [7:0] mcap [4];
  logic [7:0] cur = '0, cap = '0;
  int sl_idx = 0, sbit = 0;
  always @(posedge sck) begin
    if (sbit == 0) cur = sl_q[sl_idx];
    miso = cur[7-sbit];
  end
  always @(negedge sck) begin
    cap = {cap[6:0], mosi};
    sbit++;
    if (sbit == 8) begin
      mcap[sl_idx] = cap;
      sbit = 0;
      sl_idx = (sl_idx + 1) % 4;
    end
  end
  task automatic slv_reset();
    sl_idx = 0; sbit = 0;
  endtask

  int hi_run = 0, last_hi = 0, ss_rises = 0;
  always @(negedge clk) begin
    if (sck === 1'b1) hi_run++;
    else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
  end
  always @(posedge ss_n) ss_rises++;

  localparam logic [18:0] VEC [5] = '{
    {8'hA5, 8'h3C, 3'd0},
    {8'h01, 8'h80, 3'd1},
    {8'hFF, 8'h00, 3'd3},
    {8'h5A, 8'hC3, 3'd7},
    {8'h80, 8'h7E, 3'd2}
  };

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_tb();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ss_n", ss_n, 1);
    check("R1 sck", sck, 0);
    check("R1 irq", {irq_tx, irq_rx, irq_err, wake}, 0);
    cpu_rd(2'd0, d); check("R1 ctrl", d, 8'h00);
    cpu_rd(2'd1, d); check("R1 status", d, 8'h01);

    // Table of single transfers: R2 R4 R5 R6 R11
    for (int i = 0; i < 5; i++) begin
      logic [7:0] tx, mi;
      logic [2:0] dv;
      tx = VEC[i][18:11]; mi = VEC[i][10:3]; dv = VEC[i][2:0];
      cpu_wr(2'd0, {dv, 5'b00101});
      sl_q[0] = mi; slv_reset();
      cpu_wr(2'd2, tx);
      cpu_rd(2'd1, d); check("R2 empty set after load", d, 8'h01);
      check("R2 ss_n low", ss_n, 0);
      while (!irq_rx) @(negedge clk);
      @(negedge clk);
      check("R4 mosi byte", mcap[0], tx);
      check("R11 sck high cycles", last_hi, dv + 1);
      cpu_rd(2'd1, d); check("R5 status full", d, 8'h03);
      cpu_rd(2'd2, d); check("R5 rx byte", d, mi);
      cpu_rd(2'd1, d); check("R6 cleared", d, 8'h01);
    end

    // R3 queueing, R7 overflow, R9 interrupts and wake
    cpu_wr(2'd0, {3'd1, 5'b01101});
    sl_q[0] = 8'h11; sl_q[1] = 8'h22; slv_reset();
    ss_rises = 0;
    cpu_wr(2'd2, 8'hC1);
    cpu_wr(2'd2, 8'h3E);
    cpu_rd(2'd1, d); check("R3 queued empty=0", d, 8'h00);
    while (ss_n !== 1'b1) @(negedge clk);
    @(negedge clk);
    check("R3 single ss release", ss_rises, 1);
    check("R3 first byte", mcap[0], 8'hC1);
    check("R3 second byte", mcap[1], 8'h3E);
    check("R9 irq_err set", irq_err, 1);
    cpu_wr(2'd0, {3'd1, 5'b00101});
    check("R9 irq_err gated", irq_err, 0);
    sleep = 1'b1; #1 check("R9 wake", wake, 1);
    sleep = 1'b0; #1 check("R9 no wake", wake, 0);
    cpu_wr(2'd0, {3'd1, 5'b00011});
    check("R9 irq_tx", irq_tx, 1);
    check("R9 irq_rx gated", irq_rx, 0);
    cpu_rd(2'd1, d); check("R7 status", d, 8'h07);
    cpu_rd(2'd2, d); check("R7 earlier byte kept", d, 8'h11);
    cpu_rd(2'd1, d); check("R7 overflow cleared", d, 8'h01);

    // R12 clearing read coincides with byte completion (divider 1)
    cpu_wr(2'd0, {3'd1, 5'b00101});
    sl_q[0] = 8'h5C; sl_q[1] = 8'hA3; slv_reset();
    cpu_wr(2'd2, 8'h12);
    while (!irq_rx) @(negedge clk);
    cpu_rd(2'd1, d); check("R12 first full", d, 8'h03);
    cpu_wr(2'd2, 8'h34);
    repeat (8) @(posedge sck);
    @(posedge clk);
    @(negedge clk); addr = 2'd2; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    check("R12 ss released", ss_n, 1);
    cpu_rd(2'd1, d); check("R12 full kept, no overflow", d, 8'h03);
    cpu_rd(2'd2, d); check("R12 new byte stored", d, 8'hA3);
    cpu_rd(2'd1, d); check("R12 cleared", d, 8'h01);

    // R8 halt blocks writes; R6 data read alone does not clear
    cpu_wr(2'd0, {3'd0, 5'b00101});
    dbg_halt = 1'b1;
    cpu_wr(2'd2, 8'h77);
    repeat (4) @(negedge clk);
    check("R8 no transfer", ss_n, 1);
    cpu_rd(2'd1, d); check("R8 empty stays set", d, 8'h01);
    cpu_wr(2'd0, {3'd0, 5'b10101});
    sl_q[0] = 8'h99; slv_reset();
    cpu_wr(2'd2, 8'h66);
    while (!irq_rx) @(negedge clk);
    @(negedge clk);
    check("R8 allowed write sent", mcap[0], 8'h66);
    dbg_halt = 1'b0;
    cpu_rd(2'd2, d); check("R5 data", d, 8'h99);
    cpu_rd(2'd1, d); check("R6 data read alone keeps flag", d, 8'h03);
    cpu_rd(2'd2, d);
    cpu_rd(2'd1, d); check("R6 two-step clears", d, 8'h01);

    // R10 disable mid-transfer
    cpu_wr(2'd0, {3'd3, 5'b00101});
    sl_q[0] = 8'h00; slv_reset();
    cpu_wr(2'd2, 8'hF0);
    repeat (3) @(posedge sck);
    cpu_wr(2'd0, 8'h00);
    @(negedge clk);
    check("R10 sck low", sck, 0);
    check("R10 ss_n high", ss_n, 1);
    cpu_rd(2'd1, d); check("R10 status", d, 8'h01);
    repeat (50) @(negedge clk);
    check("R10 stays stopped", {sck, ss_n}, 2'b01);
    cpu_wr(2'd0, {3'd3, 5'b00101});
    repeat (40) @(negedge clk);
    check("R10 no stale receive", irq_rx, 0);
    check("R10 no restart", ss_n, 1);

    finish_tb();
  end
endmodule